// File: doc/BRIEF.md
# DMA Completion Event Reporter

This block closes out each DMA transfer. A transfer is identified by a tag register that holds an address. Software writes the tag before a transfer that runs without descriptors. The descriptor fetch path loads it with the system address of each descriptor block as that descriptor is processed. When the engine signals completion, the block can push the upper bits of the tag into an event queue. It can also record the outcome in a status register that drives an interrupt.

The completion request `cmpl_req_i` is held high, with its qualifiers kept stable, until `cmpl_ack_o` is returned. Per-descriptor control decides whether an event is queued and whether a successful completion is recorded. Error outcomes are always recorded. This lets a batch of transfers run quietly and raise one done indication on its final transfer. If the event queue is full, the push waits and the completion is not acknowledged until the queue takes the entry.

Top module: `dma_cmpl_rpt`

## Requirements
- R1: After reset, the tag, status register, interrupt enable mask, interrupt output, event push and busy indication are all zero.
- R2: A software write loads the full tag on the next clock edge, as does a descriptor load. When both occur in the same cycle, the descriptor address wins.
- R3: A request accepted while idle with `queue_evt_i`=1 raises `evq_push_o` in the next cycle. `evq_data_o` then holds bits [ADDR_W-1 : ADDR_W-ID_W] of the tag as it stood in the accepting cycle (by default, the upper 26 of 32 bits).
- R4: While `evq_full_i` is high during a push, `evq_push_o` stays high, `evq_data_o` stays unchanged, `busy_o` stays high and `cmpl_ack_o` stays low. `cmpl_ack_o` is asserted in the cycle the push is taken (push high, full low).
- R5: A request with `queue_evt_i`=0 is acknowledged in the same cycle it is presented while idle, and no event is pushed.
- R6: A completion with `cmpl_err_i`=0 and `inhibit_i`=0 sets status bit 0 (done) on the acknowledging clock edge.
- R7: With `inhibit_i`=1, a successful completion leaves the done bit unchanged.
- R8: On an acknowledged completion with a non-zero `cmpl_err_i`, each set bit k of `cmpl_err_i` sets status bit k+1, whatever the value of `inhibit_i`. The done bit is not set by an errored completion.
- R9: A status clear strobe clears the status bits whose mask bit is 1 and leaves the others unchanged. A status bit set in the same cycle takes priority over its clear.
- R10: `irq_o` is high exactly when some status bit and its enable bit (same bit position, written through the enable port) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmpl_req_i | input | 1 | Completion request, held until acknowledged |
| cmpl_err_i | input | ERR_W | Error code bits of the completion, zero on success |
| queue_evt_i | input | 1 | Push the tag identifier to the event queue |
| inhibit_i | input | 1 | Suppress the done bit for a successful completion |
| sw_tag_we_i | input | 1 | Software tag write strobe |
| sw_tag_i | input | ADDR_W | Software tag value |
| desc_ld_i | input | 1 | Descriptor load strobe |
| desc_addr_i | input | ADDR_W | System address of the descriptor block |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for status |
| stat_clr_mask_i | input | ERR_W+1 | Bits to clear |
| irq_en_we_i | input | 1 | Interrupt enable write strobe |
| irq_en_i | input | ERR_W+1 | Interrupt enable mask |
| evq_full_i | input | 1 | Event queue cannot accept a push |
| evq_push_o | output | 1 | Event queue push |
| evq_data_o | output | ID_W | Identifier pushed to the event queue |
| cmpl_ack_o | output | 1 | Completion accepted |
| busy_o | output | 1 | Waiting on the event queue |
| tag_o | output | ADDR_W | Current tag register |
| stat_o | output | ERR_W+1 | Status: bit 0 done, bits ERR_W:1 error bits |
| irq_o | output | 1 | Interrupt |

## Verification
The bench runs a batch in which every transfer but the last is inhibited. A design that ignored the inhibit bit would show the done bit too early, and one that applied the inhibit to errors would lose error bits. Queue stalls of several cycles are injected. A design that acknowledged early, dropped the push or re-sampled the tag during the stall would show up as wrong, missing or extra queue entries. Simultaneous software and descriptor loads, and a clear that lands on the same cycle as a new done bit, check the two priority rules. A design with either rule reversed would end with a wrong tag or a lost done bit.

// File: rtl/dma_cmpl_pkg.sv
package dma_cmpl_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PUSH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dma_cmpl_tag.sv
module dma_cmpl_tag #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_data_i,
  input  logic              desc_ld_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic [ADDR_W-1:0] tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tag_o <= '0;
    else if (desc_ld_i) tag_o <= desc_addr_i;  // hardware load wins
    else if (sw_we_i)   tag_o <= sw_data_i;
  end
endmodule

// File: rtl/dma_cmpl_seq.sv
module dma_cmpl_seq
  import dma_cmpl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              queue_i,
  input  logic [ADDR_W-1:0] tag_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [ID_W-1:0]   data_o,
  output logic              ack_o,
  output logic              busy_o
);
  localparam int ID_LSB = ADDR_W - ID_W;

  seq_state_e state_q, state_d;
  logic [ID_W-1:0] id_q;

  always_comb begin
    state_d = state_q;
    ack_o   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (req_i) begin
        if (queue_i) state_d = SEQ_PUSH;
        else         ack_o   = 1'b1;
      end
      SEQ_PUSH: if (!full_i) begin
        ack_o   = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      // snapshot so a tag reload during a stall cannot alter the entry
      if (state_q == SEQ_IDLE && req_i && queue_i) id_q <= tag_i[ADDR_W-1:ID_LSB];
    end
  end

  assign push_o = (state_q == SEQ_PUSH);
  assign busy_o = (state_q == SEQ_PUSH);
  assign data_o = id_q;
endmodule

// File: rtl/dma_cmpl_stat.sv
module dma_cmpl_stat #(
  parameter int ERR_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ack_i,
  input  logic           inhibit_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic           clr_i,
  input  logic [ERR_W:0] clr_mask_i,
  input  logic           en_we_i,
  input  logic [ERR_W:0] en_i,
  output logic [ERR_W:0] stat_o,
  output logic           irq_o
);
  logic [ERR_W:0] set_v;
  logic [ERR_W:0] clr_v;
  logic [ERR_W:0] en_q;
  logic           any_err;

  assign any_err  = |err_i;
  assign set_v[0] = ack_i && !any_err && !inhibit_i;
  assign clr_v    = clr_i ? clr_mask_i : '0;

  for (genvar k = 0; k < ERR_W; k++) begin : g_err
    assign set_v[k+1] = ack_i && err_i[k];
  end

  for (genvar k = 0; k <= ERR_W; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[k] <= 1'b0;
      else if (set_v[k]) stat_o[k] <= 1'b1;  // set beats clear
      else if (clr_v[k]) stat_o[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_i;
  end

  assign irq_o = |(stat_o & en_q);
endmodule

// File: rtl/dma_cmpl_rpt.sv
module dma_cmpl_rpt #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 26,
  parameter int ERR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpl_req_i,
  input  logic [ERR_W-1:0]  cmpl_err_i,
  input  logic              queue_evt_i,
  input  logic              inhibit_i,
  input  logic              sw_tag_we_i,
  input  logic [ADDR_W-1:0] sw_tag_i,
  input  logic              desc_ld_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic              stat_clr_i,
  input  logic [ERR_W:0]    stat_clr_mask_i,
  input  logic              irq_en_we_i,
  input  logic [ERR_W:0]    irq_en_i,
  input  logic              evq_full_i,
  output logic              evq_push_o,
  output logic [ID_W-1:0]   evq_data_o,
  output logic              cmpl_ack_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [ERR_W:0]    stat_o,
  output logic              irq_o
);
  dma_cmpl_tag #(.ADDR_W(ADDR_W)) tag_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (sw_tag_we_i),
    .sw_data_i  (sw_tag_i),
    .desc_ld_i  (desc_ld_i),
    .desc_addr_i(desc_addr_i),
    .tag_o      (tag_o)
  );

  dma_cmpl_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W)) seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (cmpl_req_i),
    .queue_i(queue_evt_i),
    .tag_i  (tag_o),
    .full_i (evq_full_i),
    .push_o (evq_push_o),
    .data_o (evq_data_o),
    .ack_o  (cmpl_ack_o),
    .busy_o (busy_o)
  );

  dma_cmpl_stat #(.ERR_W(ERR_W)) stat_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (cmpl_ack_o),
    .inhibit_i (inhibit_i),
    .err_i     (cmpl_err_i),
    .clr_i     (stat_clr_i),
    .clr_mask_i(stat_clr_mask_i),
    .en_we_i   (irq_en_we_i),
    .en_i      (irq_en_i),
    .stat_o    (stat_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/dma_cmpl_rpt_chk.sv
module dma_cmpl_rpt_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 26,
  parameter int ERR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmpl_req_i,
  input logic [ERR_W-1:0]  cmpl_err_i,
  input logic              queue_evt_i,
  input logic              inhibit_i,
  input logic              desc_ld_i,
  input logic [ADDR_W-1:0] desc_addr_i,
  input logic              evq_full_i,
  input logic              evq_push_o,
  input logic [ID_W-1:0]   evq_data_o,
  input logic              cmpl_ack_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] tag_o,
  input logic [ERR_W:0]    stat_o,
  input logic              irq_o
);
  // R2
  desc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ld_i |=> tag_o == $past(desc_addr_i));
  // R3
  push_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evq_push_o) |-> $past(cmpl_req_i && queue_evt_i && !busy_o));
  // R3
  push_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evq_push_o) |-> evq_data_o == $past(tag_o[ADDR_W-1 -: ID_W]));
  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evq_push_o && evq_full_i |=> evq_push_o && $stable(evq_data_o));
  // R4
  ack_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmpl_ack_o |-> evq_push_o && !evq_full_i);
  // R5
  no_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_req_i && !busy_o && !queue_evt_i |=> !evq_push_o);
  // R7
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_ack_o && inhibit_i && !stat_o[0] |=> !stat_o[0]);
  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_ack_o && (cmpl_err_i != '0) |=>
      ((stat_o[ERR_W:1] & $past(cmpl_err_i)) == $past(cmpl_err_i)));
  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_o != '0);
endmodule

bind dma_cmpl_rpt dma_cmpl_rpt_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .ERR_W(ERR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmpl_req_i (cmpl_req_i),
  .cmpl_err_i (cmpl_err_i),
  .queue_evt_i(queue_evt_i),
  .inhibit_i  (inhibit_i),
  .desc_ld_i  (desc_ld_i),
  .desc_addr_i(desc_addr_i),
  .evq_full_i (evq_full_i),
  .evq_push_o (evq_push_o),
  .evq_data_o (evq_data_o),
  .cmpl_ack_o (cmpl_ack_o),
  .busy_o     (busy_o),
  .tag_o      (tag_o),
  .stat_o     (stat_o),
  .irq_o      (irq_o)
);

// File: tb/dma_cmpl_rpt_tb_top.sv
`timescale 1ns/1ps
module dma_cmpl_rpt_tb_top;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 26;
  localparam int ERR_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmpl_req_i = 0;
  logic [ERR_W-1:0]  cmpl_err_i = '0;
  logic              queue_evt_i = 0, inhibit_i = 0;
  logic              sw_tag_we_i = 0;
  logic [ADDR_W-1:0] sw_tag_i = '0;
  logic              desc_ld_i = 0;
  logic [ADDR_W-1:0] desc_addr_i = '0;
  logic              stat_clr_i = 0;
  logic [ERR_W:0]    stat_clr_mask_i = '0;
  logic              irq_en_we_i = 0;
  logic [ERR_W:0]    irq_en_i = '0;
  logic              evq_full_i = 0;
  logic              evq_push_o;
  logic [ID_W-1:0]   evq_data_o;
  logic              cmpl_ack_o, busy_o, irq_o;
  logic [ADDR_W-1:0] tag_o;
  logic [ERR_W:0]    stat_o;

  always #2.5 clk_i = ~clk_i;

  dma_cmpl_rpt #(.ADDR_W(ADDR_W), .ID_W(ID_W), .ERR_W(ERR_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] tag_m = '0;
  logic [ERR_W:0]    stat_m = '0;
  logic [ID_W-1:0]   exp_ev [256];
  logic [ID_W-1:0]   got_ev [256];
  int exp_n = 0, got_n = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ERR_W:0] stat_after(input logic [ERR_W:0] s, input bit ih,
                                                 input logic [ERR_W-1:0] e);
    if (e != '0) return s | {e, 1'b0};
    if (!ih)     return s | 1;
    return s;
  endfunction

  always @(posedge clk_i)
    if (rst_ni && evq_push_o && !evq_full_i && got_n < 256) begin
      got_ev[got_n] = evq_data_o;
      got_n++;
    end

  task automatic load_tag(input bit sw, input bit ds,
                          input logic [ADDR_W-1:0] sv, input logic [ADDR_W-1:0] dv);
    @(negedge clk_i);
    sw_tag_we_i = sw; sw_tag_i = sv; desc_ld_i = ds; desc_addr_i = dv;
    @(negedge clk_i);
    sw_tag_we_i = 0; desc_ld_i = 0;
    if (ds) tag_m = dv; else if (sw) tag_m = sv;
    chk("R2 tag", tag_o, tag_m);
  endtask

  task automatic clear_stat(input logic [ERR_W:0] m);
    @(negedge clk_i);
    stat_clr_i = 1; stat_clr_mask_i = m;
    @(negedge clk_i);
    stat_clr_i = 0;
    stat_m = stat_m & ~m;
    chk("R9 clear", stat_o, stat_m);
  endtask

  task automatic cmpl(input bit q, input bit ih, input logic [ERR_W-1:0] e, input int stall);
    @(negedge clk_i);
    cmpl_req_i = 1; queue_evt_i = q; inhibit_i = ih; cmpl_err_i = e;
    evq_full_i = (stall > 0);
    if (q) begin
      exp_ev[exp_n] = tag_m[ADDR_W-1 -: ID_W];
      exp_n++;
      #1 chk("R3 no early ack", cmpl_ack_o, 0);
      @(negedge clk_i);
      chk("R3 push", evq_push_o, 1);
      chk("R3 data", evq_data_o, tag_m[ADDR_W-1 -: ID_W]);
      for (int k = 0; k < stall; k++) begin
        chk("R4 stall ack", cmpl_ack_o, 0);
        chk("R4 stall busy", busy_o, 1);
        chk("R4 stall data", evq_data_o, tag_m[ADDR_W-1 -: ID_W]);
        @(negedge clk_i);
      end
      evq_full_i = 0;
      #1 chk("R4 ack on take", cmpl_ack_o, 1);
    end else begin
      #1 chk("R5 ack", cmpl_ack_o, 1);
      chk("R5 no push", evq_push_o, 0);
    end
    @(negedge clk_i);
    cmpl_req_i = 0;
    stat_m = stat_after(stat_m, ih, e);
    chk(e != '0 ? "R8 err status" : (ih ? "R7 inhibit" : "R6 done"), stat_o, stat_m);
    chk("R4 idle after", busy_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0424));
    repeat (3) @(negedge clk_i);
    chk("R1 tag", tag_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 push", evq_push_o, 0);
    chk("R1 busy", busy_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 tag loading and priority
    load_tag(1, 0, 32'hCAFE_F00D, 32'h0);
    load_tag(0, 1, 32'h0, 32'h1234_5640);
    load_tag(1, 1, 32'hAAAA_AAAA, 32'h5555_5540);

    // R6 / R7 / R8 directed
    cmpl(0, 0, '0, 0);
    clear_stat('1);
    cmpl(0, 1, '0, 0);
    cmpl(0, 1, 4'b0101, 0);
    chk("R8 no done on err", stat_o[0], 0);
    clear_stat(5'b00010);
    clear_stat('1);

    // batch: only last uninhibited, queued events, with stalls
    for (int i = 0; i < 5; i++) begin
      load_tag(0, 1, 32'h0, 32'h8000_0000 + 32'(i) * 32'h40);
      cmpl(1, i != 4, '0, i % 3);
      chk("R7 batch done bit", stat_o[0], i == 4);
    end
    chk("R6 batch single done", $countones(stat_o), 1);
    // tag reload during stall must not alter queued id
    load_tag(1, 0, 32'hDEAD_BEC0, 32'h0);
    @(negedge clk_i);
    cmpl_req_i = 1; queue_evt_i = 1; inhibit_i = 1; cmpl_err_i = '0; evq_full_i = 1;
    exp_ev[exp_n] = tag_m[ADDR_W-1 -: ID_W]; exp_n++;
    @(negedge clk_i);
    desc_ld_i = 1; desc_addr_i = 32'h0BAD_0000;
    @(negedge clk_i);
    desc_ld_i = 0; tag_m = 32'h0BAD_0000;
    chk("R4 data held over reload", evq_data_o, 26'(32'hDEAD_BEC0 >> 6));
    evq_full_i = 0;
    @(negedge clk_i);
    cmpl_req_i = 0;

    // R9 set beats same-cycle clear
    clear_stat('1);
    @(negedge clk_i);
    cmpl_req_i = 1; queue_evt_i = 0; inhibit_i = 0; cmpl_err_i = '0;
    stat_clr_i = 1; stat_clr_mask_i = '1;
    @(negedge clk_i);
    cmpl_req_i = 0; stat_clr_i = 0;
    stat_m = 1;
    chk("R9 set wins", stat_o, 1);

    // R10 interrupt masking
    @(negedge clk_i); irq_en_we_i = 1; irq_en_i = 5'b00001;
    @(negedge clk_i); irq_en_we_i = 0;
    chk("R10 irq on", irq_o, 1);
    @(negedge clk_i); irq_en_we_i = 1; irq_en_i = 5'b11110;
    @(negedge clk_i); irq_en_we_i = 0;
    chk("R10 irq masked", irq_o, 0);
    cmpl(0, 0, 4'b1000, 0);
    chk("R10 irq err", irq_o, 1);
    clear_stat(5'b10000);
    chk("R10 irq cleared", irq_o, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) load_tag(r[0], r[1], $urandom, $urandom);
      else if (r == 3) clear_stat(5'($urandom));
      cmpl($urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0, $urandom_range(0, 3));
      chk("R10 irq", irq_o, |(stat_m & 5'b11110));
    end

    repeat (2) @(negedge clk_i);
    chk("R3 event count", got_n, exp_n);
    for (int i = 0; i < exp_n; i++) chk("R3 event entry", got_ev[i], exp_ev[i]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule